// File: doc/BRIEF.md
# Multidrop serial receiver with address filtering

This block is the receive half of a serial port meant for a bus shared by many stations. It takes an asynchronous line, oversampled sixteen times per bit by an externally supplied tick, and assembles frames of a start bit, eight data bits sent least significant bit first, an optional ninth bit and a stop bit. It also offers a synchronous shift mode in which eight bits are clocked in straight after the receive flag is cleared.

When the multiprocessor enable is set in an asynchronous mode, each frame marked as an address is compared with a station address. The station address is the own-address input with bits cleared in the mask input treated as don't-care. The frame is also compared with a broadcast address formed from the own address OR the mask. The receive flag, which software uses as its interrupt, is raised only on a match, so frames meant for other stations never disturb the processor. The flag stays set until it is cleared with a one-cycle pulse. While it is set, arriving frames are discarded.

Top module: `mpuart_addr_rx`

## Requirements
- R1: After reset, rx_flag, frame_err, rx_data and rx_bit9 are all 0.
- R2: With mp_en low in the asynchronous modes (mode 1 = 8-bit frame; modes 2 and 3 = 9-bit frame), every received frame loads rx_data with the eight data bits, received LSB first. It also loads rx_bit9 with the ninth bit (modes 2 and 3) or with the stop bit (mode 1), and sets rx_flag.
- R3: In modes 2 and 3 with mp_en high, a frame whose ninth bit is 0 leaves rx_flag clear and rx_data unchanged.
- R4: In modes 2 and 3 with mp_en high, a frame whose ninth bit is 1 is accepted when (data AND mask) equals (own_addr AND mask). With mask 8'hFF, only data equal to own_addr takes this path.
- R5: With mp_en high, a frame whose ninth bit is 1 is also accepted when every bit set in (own_addr OR mask) is also set in the data. Otherwise, when R4 does not apply either, it is rejected.
- R6: In mode 1 with mp_en high, a frame is accepted only if its address matches by R4 or R5 and its stop bit is 1. rx_bit9 then reads 1.
- R7: At the end of each asynchronous frame, frame_err is set to 1 if the stop bit was sampled low and to 0 if it was sampled high. This happens whether or not the frame is accepted.
- R8: rx_flag stays at 1 until a flag_clr pulse. While it is 1, a new frame does not change rx_data or rx_bit9.
- R9: Each bit is the majority of three samples taken at oversample counts 7, 8 and 9. A start bit whose vote is high is discarded as a glitch, and the receiver goes back to waiting for a falling edge.
- R10: In mode 0, when rx_flag is 0, the receiver shifts in eight bits, LSB first, one per 16 ticks, starting on the next tick. It then loads rx_data, clears rx_bit9 and sets rx_flag, whatever the value of mp_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial receive line |
| mode | input | 2 | 0 shift, 1 8-bit async, 2/3 9-bit async |
| mp_en | input | 1 | Multiprocessor address filtering enable |
| own_addr | input | 8 | Station address |
| addr_mask | input | 8 | Address mask, 0 bits are don't-care |
| flag_clr | input | 1 | One-cycle pulse clearing rx_flag |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit (or stop bit in mode 1) of last accepted frame |
| rx_flag | output | 1 | Receive flag |
| frame_err | output | 1 | Stop bit of the last asynchronous frame was low |

## Verification
The assertions assume that mode, mp_en, own_addr and addr_mask are steady while a frame is in flight. They also assume that flag_clr is a short pulse that is not needed in the same cycle that a frame completes. The bench changes the configuration only while the line is idle and well after the previous stop bit has been decided. It issues flag_clr only between frames, and it holds each bit for exactly sixteen ticks, so that every vote falls inside a stable bit.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP,
    ST_SHIFT
  } rx_state_e;

  localparam logic [1:0] MODE_SHIFT = 2'd0;
  localparam logic [1:0] MODE_8BIT  = 2'd1;

  function automatic logic majority3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[1] & s[2]) | (s[0] & s[2]);
  endfunction

  function automatic logic station_hit(input logic [DATA_W-1:0] data,
                                       input logic [DATA_W-1:0] own,
                                       input logic [DATA_W-1:0] mask);
    return (data & mask) == (own & mask);
  endfunction

  function automatic logic broadcast_hit(input logic [DATA_W-1:0] data,
                                         input logic [DATA_W-1:0] own,
                                         input logic [DATA_W-1:0] mask);
    logic [DATA_W-1:0] bc;
    bc = own | mask;
    return (data & bc) == bc;
  endfunction

endpackage

// File: rtl/mpuart_sampler.sv
module mpuart_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  input  logic sample_en,
  output logic line,
  output logic vote
);
  import mpuart_pkg::*;

  logic       sync1;
  logic [2:0] samples;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= 1'b1;
      line    <= 1'b1;
      samples <= 3'b111;
    end else begin
      sync1 <= rxd;
      line  <= sync1;
      if (tick && sample_en) samples <= {samples[1:0], line};
    end
  end

  assign vote = majority3(samples);
endmodule

// File: rtl/mpuart_addr_filter.sv
module mpuart_addr_filter
  import mpuart_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic              mp_en,
  input  logic [DATA_W-1:0] data,
  input  logic              bit9,
  input  logic [DATA_W-1:0] own_addr,
  input  logic [DATA_W-1:0] addr_mask,
  output logic              addr_hit,
  output logic              pass
);
  always_comb begin
    addr_hit = station_hit(data, own_addr, addr_mask) ||
               broadcast_hit(data, own_addr, addr_mask);
    if (!mp_en || mode == MODE_SHIFT) pass = 1'b1;
    else                              pass = bit9 && addr_hit;
  end
endmodule

// File: rtl/mpuart_addr_rx.sv
module mpuart_addr_rx
  import mpuart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic [1:0]        mode,
  input  logic              mp_en,
  input  logic [DATA_W-1:0] own_addr,
  input  logic [DATA_W-1:0] addr_mask,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_flag,
  output logic              frame_err
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              ninth;

  logic line, vote, sample_en, slot_end, nine_mode;
  logic frame_done, sync_done, stop_bit, frame_bit9;
  logic addr_hit, filter_pass, frame_accept;
  logic [DATA_W-1:0] shifted, load_byte;

  assign nine_mode = mode[1];
  assign slot_end  = tick && (cnt == CNT_LAST);
  assign sample_en = (state != ST_IDLE) &&
                     (cnt >= CNT_MID - 1'b1) && (cnt <= CNT_MID + 1'b1);
  assign shifted   = {vote, shreg[DATA_W-1:1]};

  mpuart_sampler u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rxd       (rxd),
    .sample_en (sample_en),
    .line      (line),
    .vote      (vote)
  );

  // named frame events
  assign frame_done = slot_end && (state == ST_STOP);
  assign sync_done  = slot_end && (state == ST_SHIFT) && (idx == IDX_LAST);
  assign stop_bit   = vote;
  assign frame_bit9 = nine_mode ? ninth : stop_bit;
  assign load_byte  = sync_done ? shifted : shreg;

  mpuart_addr_filter u_filter (
    .mode      (mode),
    .mp_en     (mp_en),
    .data      (shreg),
    .bit9      (frame_bit9),
    .own_addr  (own_addr),
    .addr_mask (addr_mask),
    .addr_hit  (addr_hit),
    .pass      (filter_pass)
  );

  assign frame_accept = !rx_flag && (sync_done || (frame_done && filter_pass));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      ninth <= 1'b0;
    end else if (tick) begin
      cnt <= slot_end ? '0 : cnt + 1'b1;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          idx <= '0;
          if (mode == MODE_SHIFT) begin
            if (!rx_flag) state <= ST_SHIFT;
          end else if (!line) begin
            state <= ST_START;
          end
        end
        ST_START:
          if (slot_end) state <= vote ? ST_IDLE : ST_DATA;
        ST_DATA:
          if (slot_end) begin
            shreg <= shifted;
            idx   <= idx + 1'b1;
            if (idx == IDX_LAST) state <= nine_mode ? ST_NINTH : ST_STOP;
          end
        ST_NINTH:
          if (slot_end) begin
            ninth <= vote;
            state <= ST_STOP;
          end
        ST_STOP:
          if (slot_end) state <= ST_IDLE;
        ST_SHIFT:
          if (slot_end) begin
            shreg <= shifted;
            idx   <= idx + 1'b1;
            if (idx == IDX_LAST) state <= ST_IDLE;
          end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_bit9   <= 1'b0;
      rx_flag   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (frame_done) frame_err <= !stop_bit;
      if (frame_accept) begin
        rx_data <= load_byte;
        rx_bit9 <= sync_done ? 1'b0 : frame_bit9;
        rx_flag <= 1'b1;
      end else if (flag_clr) begin
        rx_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mpuart_addr_rx_chk.sv
module mpuart_addr_rx_chk
  import mpuart_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              mp_en,
  input logic              flag_clr,
  input logic              rx_flag,
  input logic [DATA_W-1:0] rx_data,
  input logic              frame_err,
  input logic              frame_done,
  input logic              sync_done,
  input logic              stop_bit,
  input logic              frame_bit9,
  input logic              addr_hit
);
  // flag only rises at the end of a frame
  assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !$past(rx_flag)) |-> ($past(frame_done) || $past(sync_done)));

  assert_data_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && $past(rx_flag)) |-> $stable(rx_data));

  assert_data_frame_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && mode[1] && mp_en && !frame_bit9 && !rx_flag) |=> !rx_flag);

  assert_no_match_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && mode != MODE_SHIFT && mp_en && !addr_hit && !rx_flag) |=> !rx_flag);

  assert_bad_stop_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && mode == MODE_8BIT && mp_en && !stop_bit && !rx_flag) |=> !rx_flag);

  assert_frame_err_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (frame_err == !$past(stop_bit)));

  assert_shift_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_done && !rx_flag) |=> rx_flag);

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !frame_done && !sync_done) |=> !rx_flag);
endmodule

bind mpuart_addr_rx mpuart_addr_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .mp_en      (mp_en),
  .flag_clr   (flag_clr),
  .rx_flag    (rx_flag),
  .rx_data    (rx_data),
  .frame_err  (frame_err),
  .frame_done (frame_done),
  .sync_done  (sync_done),
  .stop_bit   (stop_bit),
  .frame_bit9 (frame_bit9),
  .addr_hit   (addr_hit)
);

// File: tb/mpuart_addr_rx_tb.sv
module mpuart_addr_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] mode = 2'd2;
  logic       mp_en = 1'b0;
  logic [7:0] own_addr = 8'h00;
  logic [7:0] addr_mask = 8'hFF;
  logic       flag_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_flag, frame_err;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  mpuart_addr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .mode(mode),
    .mp_en(mp_en), .own_addr(own_addr), .addr_mask(addr_mask),
    .flag_clr(flag_clr), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_flag(rx_flag), .frame_err(frame_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (16) @(negedge clk);
  endtask

  // one asynchronous frame, then idle time
  task automatic send(input logic [7:0] d, input logic nine, input logic b9,
                      input logic stop_v);
    @(negedge clk);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i]);
    if (nine) hold_bit(b9);
    hold_bit(stop_v);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "flag", {7'd0, rx_flag}, 8'h00);
    chk("R1", "frame_err", {7'd0, frame_err}, 8'h00);
    chk("R1", "data", rx_data, 8'h00);
    chk("R1", "bit9", {7'd0, rx_bit9}, 8'h00);
  endtask

  task automatic t_plain_r2();
    mode = 2'd2; mp_en = 1'b0;
    send(8'hA5, 1'b1, 1'b0, 1'b1);
    chk("R2", "flag", {7'd0, rx_flag}, 8'h01);
    chk("R2", "data", rx_data, 8'hA5);
    chk("R2", "bit9", {7'd0, rx_bit9}, 8'h00);
    clear_flag();
    mode = 2'd3;
    send(8'h3C, 1'b1, 1'b1, 1'b1);
    chk("R2", "data mode3", rx_data, 8'h3C);
    chk("R2", "bit9 mode3", {7'd0, rx_bit9}, 8'h01);
    clear_flag();
  endtask

  task automatic t_given_r3_r4();
    mode = 2'd2; mp_en = 1'b1; own_addr = 8'h56; addr_mask = 8'hFC;
    send(8'h55, 1'b1, 1'b1, 1'b1);
    chk("R4", "masked match flag", {7'd0, rx_flag}, 8'h01);
    chk("R4", "masked match data", rx_data, 8'h55);
    clear_flag();
    send(8'h57, 1'b1, 1'b0, 1'b1);
    chk("R3", "data frame flag", {7'd0, rx_flag}, 8'h00);
    chk("R3", "data frame data", rx_data, 8'h55);
    send(8'h5A, 1'b1, 1'b1, 1'b1);
    chk("R4", "mismatch flag", {7'd0, rx_flag}, 8'h00);
    addr_mask = 8'hFF;
    send(8'h57, 1'b1, 1'b1, 1'b1);
    chk("R4", "exact mismatch flag", {7'd0, rx_flag}, 8'h00);
    send(8'h56, 1'b1, 1'b1, 1'b1);
    chk("R4", "exact match flag", {7'd0, rx_flag}, 8'h01);
    chk("R4", "exact match data", rx_data, 8'h56);
    clear_flag();
  endtask

  task automatic t_broadcast_r5();
    mode = 2'd3; mp_en = 1'b1; own_addr = 8'h56; addr_mask = 8'hFC;
    send(8'hFF, 1'b1, 1'b1, 1'b1);
    chk("R5", "broadcast flag", {7'd0, rx_flag}, 8'h01);
    chk("R5", "broadcast data", rx_data, 8'hFF);
    clear_flag();
    send(8'hBE, 1'b1, 1'b1, 1'b1);
    chk("R5", "near broadcast flag", {7'd0, rx_flag}, 8'h00);
  endtask

  task automatic t_mode1_r6_r7();
    mode = 2'd1; mp_en = 1'b1; own_addr = 8'h56; addr_mask = 8'hFF;
    send(8'h56, 1'b0, 1'b0, 1'b0);
    chk("R6", "bad stop flag", {7'd0, rx_flag}, 8'h00);
    chk("R7", "bad stop frame_err", {7'd0, frame_err}, 8'h01);
    send(8'h56, 1'b0, 1'b0, 1'b1);
    chk("R6", "good stop flag", {7'd0, rx_flag}, 8'h01);
    chk("R6", "good stop bit9", {7'd0, rx_bit9}, 8'h01);
    chk("R7", "good stop frame_err", {7'd0, frame_err}, 8'h00);
    clear_flag();
    mp_en = 1'b0;
    send(8'h12, 1'b0, 1'b0, 1'b1);
    chk("R2", "mode1 data", rx_data, 8'h12);
  endtask

  task automatic t_hold_r8();
    send(8'h99, 1'b0, 1'b0, 1'b1);
    chk("R8", "held flag", {7'd0, rx_flag}, 8'h01);
    chk("R8", "held data", rx_data, 8'h12);
    clear_flag();
    chk("R8", "cleared flag", {7'd0, rx_flag}, 8'h00);
  endtask

  task automatic t_glitch_r9();
    @(negedge clk);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    chk("R9", "glitch flag", {7'd0, rx_flag}, 8'h00);
    send(8'h6B, 1'b0, 1'b0, 1'b1);
    chk("R9", "after glitch data", rx_data, 8'h6B);
    chk("R9", "after glitch flag", {7'd0, rx_flag}, 8'h01);
    clear_flag();
  endtask

  task automatic t_shift_r10();
    logic [7:0] pat;
    pat = 8'hC3;
    mp_en = 1'b1; own_addr = 8'h00; addr_mask = 8'hFF;
    @(negedge clk);
    mode = 2'd0;
    for (int i = 0; i < 8; i++) hold_bit(pat[i]);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
    chk("R10", "shift flag", {7'd0, rx_flag}, 8'h01);
    chk("R10", "shift data", rx_data, 8'hC3);
    chk("R10", "shift bit9", {7'd0, rx_bit9}, 8'h00);
    mode = 2'd1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_plain_r2();
    t_given_r3_r4();
    t_broadcast_r5();
    t_mode1_r6_r7();
    t_hold_r8();
    t_glitch_r9();
    t_shift_r10();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule